// File: doc/BRIEF.md
# Triggered Fractional Clock-Enable Divider

This block turns a free-running clock enable into a slower one-cycle tick stream. The ratio is a fixed-point number. A register field holds the amount by which the divisor exceeds 1.0, counted in units of 2^-F. An accumulator adds 2^F on each enabled input cycle. Whenever the accumulator reaches the scaled divisor, the block emits a tick and subtracts the divisor. As a result, the long-run average tick rate is the input rate times 2^F divided by the scaled divisor, with no drift.

Software stages a new divisor through a small register port. The staged value does nothing until a self-clearing go bit is written in the control register. That bit reads as busy until the new value has been taken in. The switch happens on the next tick of the divider being changed, and its accumulator restarts from zero at that point. So the cadence after a switch is fully determined. A switch is only taken while the output gate is open and input enables are arriving.

An optional pre-divider of the same kind sits in front of the main divider. Its ticks serve as the main divider's enable. It has its own field and its own go bit.

Top module: `frac_div_top`

## Requirements
- R1: With a main field of 0 the scaled divisor equals 2^F, and the main divider ticks on every cycle in which its enable is high (the pre-divider output, or `clk_en_i` when there is no pre-divider).
- R2: The scaled divisor is the field value plus 2^F. Counting from the cycle in which a new divisor takes effect, the number of ticks over the next n enabled cycles is floor(n·2^F / divisor).
- R3: Register 0 holds the main field at bits [MAIN_SHIFT+MAIN_W-1:MAIN_SHIFT], and register 1 holds the pre-divider field at bits [PRE_SHIFT+PRE_W-1:PRE_SHIFT]. A write changes only that field, and every other bit reads 0.
- R4: A value written to a field register does not change the tick rate until the matching go bit is written. Reading the register returns the staged value.
- R5: Register 2 bit 0 (main go) and bit 1 (pre-divider go) are set by writing 1 and ignore a written 0. Each reads 1 while its switch is pending and clears itself on the tick edge where the new divisor is applied.
- R6: A pending switch stays pending, with its go bit reading 1, for as long as `clk_en_i` is held low. While the enable is low, no ticks come out.
- R7: Register 2 bit 2 is the output gate, and it resets to 1. While it is 0, `tick_o` stays low and any pending switch stays pending. The switch completes once the gate is reopened.
- R8: When the pre-divider is present, its ticks are the main divider's enable. With the main field at 0, the count at `tick_o` follows floor(n·2^PF / pre divisor) from the pre-divider switch.
- R9: After reset, register 0 reads MAIN_RST<<MAIN_SHIFT, register 1 reads PRE_RST<<PRE_SHIFT, register 2 reads 4 (gate open, nothing pending), and `tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Input clock enable that is divided |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select (0 main field, 1 pre field, 2 control) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_o | output | 1 | Divided one-cycle tick, gated by the output gate |

## Verification
The bench builds the block with its default parameters:
- main field of 4 bits with 2 fraction bits at shift 4;
- pre-divider present, with 3 bits and 1 fraction bit at shift 8.

This keeps every main divisor (1.0 to 4.75) and every pre divisor (1.0 to 4.5) small enough to sweep in full. For each one, it counts ticks over 64 cycles from the exact switch edge and compares the count with floor(64·2^F/D). Those same small settings also make the fractional cadences and the gate and enable holds short enough to observe.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
   typedef enum logic [1:0] {
      REG_MAIN = 2'd0,
      REG_PRE  = 2'd1,
      REG_CTRL = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int CTL_MAIN_GO = 0;
   localparam int CTL_PRE_GO  = 1;
   localparam int CTL_GATE    = 2;
endpackage

// File: rtl/frac_div_core.sv
module frac_div_core #(
   parameter int FIELD_W   = 4,
   parameter int FRAC_W    = 2,
   parameter int RST_FIELD = 0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               allow_i,
   input  logic [FIELD_W-1:0] staged_i,
   input  logic               trig_i,
   output logic               busy_o,
   output logic               tick_o
);
   localparam int AW = FIELD_W + 2;
   localparam logic [AW-1:0] STEP = AW'(1) << FRAC_W;

   logic [FIELD_W-1:0] active_q;
   logic [AW-1:0]      acc_q;
   logic               pend_q;
   logic               tick_q;

   logic [AW-1:0] div_w;
   logic [AW-1:0] sum_w;
   logic          hit_w;
   logic          apply_w;

   always_comb begin
      div_w   = AW'(active_q) + STEP;
      sum_w   = acc_q + STEP;
      hit_w   = en_i && (sum_w >= div_w);
      apply_w = pend_q && hit_w && allow_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= FIELD_W'(RST_FIELD);
         acc_q    <= '0;
         pend_q   <= 1'b0;
         tick_q   <= 1'b0;
      end else begin
         tick_q <= hit_w;
         if (apply_w) begin
            active_q <= staged_i;
            acc_q    <= '0;
         end else if (hit_w) begin
            acc_q <= sum_w - div_w;
         end else if (en_i) begin
            acc_q <= sum_w;
         end
         if (trig_i)
            pend_q <= 1'b1;
         else if (apply_w)
            pend_q <= 1'b0;
      end
   end

   assign busy_o = pend_q;
   assign tick_o = tick_q;

   AST_UNITY_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && active_q == '0) |=> tick_q); // R1
   AST_ACC_BELOW_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q < div_w); // R2
   AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_q |=> $stable(active_q)); // R4
   AST_PEND_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q) |-> $past(en_i && allow_i)); // R6
   AST_NO_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !tick_q); // R6
endmodule

// File: rtl/frac_div_regs.sv
module frac_div_regs
   import frac_div_pkg::*;
#(
   parameter int MAIN_W     = 4,
   parameter int MAIN_SHIFT = 4,
   parameter int MAIN_RST   = 4,
   parameter bit HAS_PRE    = 1'b1,
   parameter int PRE_W      = 3,
   parameter int PRE_SHIFT  = 8,
   parameter int PRE_RST    = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [31:0]       wdata_i,
   input  logic              main_busy_i,
   input  logic              pre_busy_i,
   output logic [MAIN_W-1:0] main_field_o,
   output logic [PRE_W-1:0]  pre_field_o,
   output logic              main_trig_o,
   output logic              pre_trig_o,
   output logic              gate_o,
   output logic [31:0]       rdata_o
);
   logic [MAIN_W-1:0] main_q;
   logic [PRE_W-1:0]  pre_q;
   logic              gate_q;
   logic              wr_main, wr_pre, wr_ctl;
   logic [31:0]       pre_rd;

   assign wr_main = wr_en_i && (addr_i == REG_MAIN);
   assign wr_pre  = wr_en_i && (addr_i == REG_PRE);
   assign wr_ctl  = wr_en_i && (addr_i == REG_CTRL);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         main_q <= MAIN_W'(MAIN_RST);
         gate_q <= 1'b1;
      end else begin
         if (wr_main)
            main_q <= wdata_i[MAIN_SHIFT +: MAIN_W];
         if (wr_ctl)
            gate_q <= wdata_i[CTL_GATE];
      end
   end

   generate
      if (HAS_PRE) begin : g_pre
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               pre_q <= PRE_W'(PRE_RST);
            else if (wr_pre)
               pre_q <= wdata_i[PRE_SHIFT +: PRE_W];
         end
         assign pre_trig_o = wr_ctl && wdata_i[CTL_PRE_GO];
         assign pre_rd     = 32'(pre_q) << PRE_SHIFT;
      end else begin : g_nopre
         assign pre_q      = PRE_W'(PRE_RST);
         assign pre_trig_o = 1'b0;
         assign pre_rd     = '0;
      end
   endgenerate

   assign main_trig_o  = wr_ctl && wdata_i[CTL_MAIN_GO];
   assign main_field_o = main_q;
   assign pre_field_o  = pre_q;
   assign gate_o       = gate_q;

   always_comb begin
      unique case (addr_i)
         REG_MAIN: rdata_o = 32'(main_q) << MAIN_SHIFT;
         REG_PRE:  rdata_o = pre_rd;
         REG_CTRL: rdata_o = {29'd0, gate_q, pre_busy_i, main_busy_i};
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/frac_div_top.sv
module frac_div_top #(
   parameter int MAIN_W     = 4,
   parameter int MAIN_FRAC  = 2,
   parameter int MAIN_SHIFT = 4,
   parameter int MAIN_RST   = 4,
   parameter bit HAS_PRE    = 1'b1,
   parameter int PRE_W      = 3,
   parameter int PRE_FRAC   = 1,
   parameter int PRE_SHIFT  = 8,
   parameter int PRE_RST    = 0
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        clk_en_i,
   input  logic        wr_en_i,
   input  logic [1:0]  addr_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rdata_o,
   output logic        tick_o
);
   generate
      if (MAIN_FRAC >= MAIN_W) begin : g_bad_main_frac
         $error("MAIN_FRAC must be below MAIN_W");
      end
      if (MAIN_SHIFT + MAIN_W > 32) begin : g_bad_main_pos
         $error("main field exceeds 32 bits");
      end
      if (HAS_PRE && (PRE_FRAC >= PRE_W)) begin : g_bad_pre_frac
         $error("PRE_FRAC must be below PRE_W");
      end
      if (HAS_PRE && (PRE_SHIFT + PRE_W > 32)) begin : g_bad_pre_pos
         $error("pre field exceeds 32 bits");
      end
   endgenerate

   logic [MAIN_W-1:0] main_field;
   logic [PRE_W-1:0]  pre_field;
   logic main_trig, pre_trig, gate;
   logic main_busy, pre_busy;
   logic main_en, main_tick;

   frac_div_regs #(
      .MAIN_W(MAIN_W), .MAIN_SHIFT(MAIN_SHIFT), .MAIN_RST(MAIN_RST),
      .HAS_PRE(HAS_PRE), .PRE_W(PRE_W), .PRE_SHIFT(PRE_SHIFT), .PRE_RST(PRE_RST)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .main_busy_i(main_busy), .pre_busy_i(pre_busy),
      .main_field_o(main_field), .pre_field_o(pre_field),
      .main_trig_o(main_trig), .pre_trig_o(pre_trig), .gate_o(gate),
      .rdata_o(rdata_o)
   );

   generate
      if (HAS_PRE) begin : g_pre
         frac_div_core #(.FIELD_W(PRE_W), .FRAC_W(PRE_FRAC), .RST_FIELD(PRE_RST)) u_pre (
            .clk_i(clk_i), .rst_ni(rst_ni), .en_i(clk_en_i), .allow_i(gate),
            .staged_i(pre_field), .trig_i(pre_trig), .busy_o(pre_busy),
            .tick_o(main_en)
         );
      end else begin : g_direct
         assign main_en  = clk_en_i;
         assign pre_busy = 1'b0;
      end
   endgenerate

   frac_div_core #(.FIELD_W(MAIN_W), .FRAC_W(MAIN_FRAC), .RST_FIELD(MAIN_RST)) u_main (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(main_en), .allow_i(gate),
      .staged_i(main_field), .trig_i(main_trig), .busy_o(main_busy),
      .tick_o(main_tick)
   );

   assign tick_o = main_tick & gate;

   AST_GATED_SWITCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gate && main_busy && !wr_en_i) |=> main_busy); // R7
endmodule

// File: tb/sim_frac_div_top.sv
`timescale 1ns/1ps
module sim_frac_div_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1;
   logic wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic tick;
   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   frac_div_top u0 (
      .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic poll(input int bitn, input string req);
      logic [31:0] d;
      int n = 0;
      rd(2'd2, d);
      while (d[bitn] && n < 500) begin
         @(negedge clk);
         rd(2'd2, d);
         n++;
      end
      if (n >= 500) chk(req, 1, 0);
   endtask

   task automatic count(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         if (tick) c++;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog act=%0d exp=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int c;
      repeat (3) @(negedge clk);
      #1;
      chk("R9 tick", int'(tick), 0);
      rst_n = 1'b1;
      rd(2'd0, d); chk("R9 main reg", int'(d), 32'h40);
      rd(2'd1, d); chk("R9 pre reg", int'(d), 0);
      rd(2'd2, d); chk("R9 ctrl reg", int'(d), 4);

      // R3: only field bits change and read back
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R3 main field", int'(d), 32'hF0);
      wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R3 pre field", int'(d), 32'h700);
      wr(2'd0, 32'h0000_0040); wr(2'd1, 32'h0);

      // R2 sweep of every main field, pre at divide-by-one
      for (int f = 0; f < 16; f++) begin
         wr(2'd0, 32'(f) << 4);
         wr(2'd2, 32'h5);
         poll(0, "R5 main go");
         count(64, c);
         chk($sformatf("R2 main field %0d", f), c, (64 * 4) / (f + 4));
      end

      // R4 staged value has no effect without go; R5 a written 0 is ignored
      wr(2'd0, 32'h40); wr(2'd2, 32'h5); poll(0, "R5 main go");
      wr(2'd0, 32'h00);
      wr(2'd2, 32'h4);
      rd(2'd2, d); chk("R5 zero go ignored", int'(d[0]), 0);
      count(64, c); chk("R4 rate unchanged", c, 32);
      rd(2'd0, d); chk("R4 staged readback", int'(d), 0);
      wr(2'd2, 32'h5); poll(0, "R5 main go");
      count(64, c); chk("R1 unity divide", c, 64);

      // R8 sweep of every pre field, main at unity
      for (int p = 0; p < 8; p++) begin
         wr(2'd1, 32'(p) << 8);
         wr(2'd2, 32'h6);
         poll(1, "R5 pre go");
         @(negedge clk);
         count(64, c);
         chk($sformatf("R8 pre field %0d", p), c, (64 * 2) / (p + 2));
      end
      wr(2'd1, 32'h0); wr(2'd2, 32'h6); poll(1, "R5 pre go");

      // R6 enable low holds the switch pending
      wr(2'd0, 32'hF0);
      @(negedge clk); en = 1'b0;
      wr(2'd2, 32'h5);
      rd(2'd2, d); chk("R5 busy after go", int'(d[0]), 1);
      repeat (4) @(negedge clk);
      count(20, c); chk("R6 no ticks while idle", c, 0);
      rd(2'd2, d); chk("R6 still pending", int'(d[0]), 1);
      en = 1'b1;
      poll(0, "R6 main go");
      count(64, c); chk("R6 rate after resume", c, 13);

      // R7 gate closed
      wr(2'd2, 32'h0);
      count(20, c); chk("R7 gated output", c, 0);
      wr(2'd0, 32'h20);
      wr(2'd2, 32'h1);
      repeat (20) @(negedge clk);
      rd(2'd2, d); chk("R7 pending while gated", int'(d[0]), 1);
      wr(2'd2, 32'h4);
      poll(0, "R7 main go");
      count(64, c); chk("R7 rate after reopen", c, 42);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule